// File: doc/BRIEF.md
# Framed Serial Word Receiver with Link Lock

This block sits at the receiving end of a one-wire serial link. It gets a bit stream together with a clock that is already aligned to the bits. After reset it hunts for a startup training sequence. In that sequence, every run of ones is followed by a run of zeros of the same length. Once enough balanced periods have arrived back to back, the block raises a lock indication toward the transmitter. The lock tells the transmitter that words can now be sent.

While locked, the stream is cut into frames. Each frame is one start bit (always 1), then `DATA_W` payload bits with the most significant bit first, then one stop bit (always 0). Every good frame yields a parallel word with a one-cycle valid strobe. A bad start or stop bit raises a one-cycle framing-error pulse and drops lock. That change asks the transmitter to send the training sequence again, and the block goes back to hunting.

Top module: `frame_lock_rx`

## Requirements
- R1: While reset is held and in the first cycles after reset, `lock_o`, `word_vld_o` and `frame_err_o` are all 0.
- R2: A balanced period is a run of L ones followed by exactly L zeros, and it closes when the next 1 is sampled. Zeros that arrive before the first 1 of a hunt are ignored.
- R3: `lock_o` rises in the cycle after the 1 that closes the `SYNC_PERIODS`-th balanced period in a row (default 4). That same 1 counts as the start bit of the first frame.
- R4: A period whose zero run is not exactly as long as its one run resets the consecutive-period count to zero.
- R5: A run of `RUN_MAX` or more equal bits (default 16) never makes a balanced period. Runs of length 1 up to `RUN_MAX`-1 can.
- R6: While locked, a frame is `DATA_W`+2 bits long: start=1, `DATA_W` data bits, stop=0. The first data bit received lands in bit `DATA_W`-1 of `word_o`.
- R7: `word_vld_o` is high for exactly the one cycle after a good stop bit is sampled. In that cycle `word_o` holds the frame's payload. It is low during all other bits.
- R8: A stop bit of 1 gives a one-cycle `frame_err_o` pulse and drops `lock_o` in the cycle after that bit, and no valid strobe is produced.
- R9: A 0 where a start bit is expected gives a one-cycle `frame_err_o` pulse and drops `lock_o` in the cycle after that bit.
- R10: While lock holds, frames can follow each other with no gap, and each good frame yields its own word.
- R11: After lock is lost, the hunt starts again from a count of zero, and a fresh training sequence locks the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial data bit |
| lock_o | output | 1 | Link locked, sent back to the transmitter |
| word_o | output | DATA_W | Recovered payload word |
| word_vld_o | output | 1 | One-cycle strobe for a new word on `word_o` |
| frame_err_o | output | 1 | One-cycle pulse on a bad start or stop bit |

## Verification
The training hunt is driven with balanced periods of random lengths, and the bench checks that lock appears on exactly the closing 1 of the required period. It also drives a period one zero too long, which must restart the count, and runs at and just below the length limit, which tell saturation apart from a match. Locked reception uses fixed and random payloads sent back to back, which show the bit order and that the strobe lasts one cycle. A bad stop bit and a bad start bit are each injected to check the error pulse, the loss of lock and a later relock.

// File: rtl/frx_pkg.sv
package frx_pkg;

  // Phase of the run-length meter while hunting for training
  typedef enum logic [1:0] {
    RUN_IDLE  = 2'd0,
    RUN_ONES  = 2'd1,
    RUN_ZEROS = 2'd2
  } run_phase_e;

  // Link state seen by the transmitter
  typedef enum logic {
    LK_HUNT   = 1'b0,
    LK_LOCKED = 1'b1
  } lock_state_e;

endpackage

// File: rtl/frx_run_meter.sv
module frx_run_meter #(
  parameter int RUN_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en,
  input  logic bit_in,
  output logic period_end,
  output logic period_bal
);
  import frx_pkg::*;

  localparam int RUN_W = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);

  run_phase_e       phase_q, phase_d;
  logic [RUN_W-1:0] ones_q, ones_d;
  logic [RUN_W-1:0] zeros_q, zeros_d;

  function automatic logic [RUN_W-1:0] sat_inc(input logic [RUN_W-1:0] v);
    return (v == RUN_SAT) ? v : v + RUN_W'(1);
  endfunction

  // A period closes on the first 1 after its zero run
  always_comb begin
    period_end = hunt_en && (phase_q == RUN_ZEROS) && bit_in;
    period_bal = period_end && (ones_q == zeros_q) && (ones_q != RUN_SAT);
  end

  always_comb begin
    phase_d = phase_q;
    ones_d  = ones_q;
    zeros_d = zeros_q;
    if (!hunt_en) begin
      phase_d = RUN_IDLE;
      ones_d  = '0;
      zeros_d = '0;
    end else begin
      unique case (phase_q)
        RUN_IDLE: begin
          if (bit_in) begin
            phase_d = RUN_ONES;
            ones_d  = RUN_W'(1);
          end
        end
        RUN_ONES: begin
          if (bit_in) begin
            ones_d = sat_inc(ones_q);
          end else begin
            phase_d = RUN_ZEROS;
            zeros_d = RUN_W'(1);
          end
        end
        RUN_ZEROS: begin
          if (bit_in) begin
            phase_d = RUN_ONES;
            ones_d  = RUN_W'(1);
            zeros_d = '0;
          end else begin
            zeros_d = sat_inc(zeros_q);
          end
        end
        default: phase_d = RUN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= RUN_IDLE;
      ones_q  <= '0;
      zeros_q <= '0;
    end else begin
      phase_q <= phase_d;
      ones_q  <= ones_d;
      zeros_q <= zeros_d;
    end
  end

  // R5
  run_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q <= RUN_SAT) && (zeros_q <= RUN_SAT));

  // R2
  zero_run_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == RUN_ZEROS) |-> (ones_q != '0));

endmodule

// File: rtl/frx_framer.sv
module frx_framer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_en,
  input  logic              bit_in,
  output logic              frame_fail,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);

  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              at_start, at_stop, stop_ok;

  always_comb begin
    at_start   = (idx_q == '0);
    at_stop    = (idx_q == STOP_IDX);
    frame_fail = frame_en && ((at_start && !bit_in) || (at_stop && bit_in));
    stop_ok    = frame_en && at_stop && !bit_in;

    // Out of lock the next bit is the first payload bit
    if (!frame_en)    idx_d = IDX_W'(1);
    else if (at_stop) idx_d = '0;
    else              idx_d = idx_q + IDX_W'(1);

    shreg_d = shreg_q;
    if (frame_en && !at_start && !at_stop)
      shreg_d = {shreg_q[DATA_W-2:0], bit_in};

    word_d = stop_ok ? shreg_q : word_q;
    vld_d  = stop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= IDX_W'(1);
      shreg_q <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      word_q  <= word_d;
      vld_q   <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= STOP_IDX);

  // R7
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/frame_lock_rx.sv
module frame_lock_rx #(
  parameter int DATA_W       = 8,
  parameter int SYNC_PERIODS = 4,
  parameter int RUN_MAX      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic              lock_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_err_o
);
  import frx_pkg::*;

  localparam int BAL_W = $clog2(SYNC_PERIODS + 1);
  localparam logic [BAL_W-1:0] BAL_LAST = BAL_W'(SYNC_PERIODS - 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  lock_state_e      state_q, state_d;
  logic [BAL_W-1:0] bal_q, bal_d;
  logic             ferr_q, ferr_d;
  logic             per_end, per_bal, frame_fail;
  logic             hunt_en, frame_en;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign hunt_en  = (state_q == LK_HUNT);
  assign frame_en = (state_q == LK_LOCKED);

  frx_run_meter #(.RUN_MAX(RUN_MAX)) u_run_meter (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hunt_en    (hunt_en),
    .bit_in     (ser_in),
    .period_end (per_end),
    .period_bal (per_bal)
  );

  frx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .frame_en   (frame_en),
    .bit_in     (ser_in),
    .frame_fail (frame_fail),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  always_comb begin
    state_d = state_q;
    bal_d   = bal_q;
    ferr_d  = frame_fail;
    unique case (state_q)
      LK_HUNT: begin
        if (per_end) begin
          if (!per_bal) begin
            bal_d = '0;
          end else if (bal_q == BAL_LAST) begin
            state_d = LK_LOCKED;
            bal_d   = '0;
          end else begin
            bal_d = bal_q + BAL_W'(1);
          end
        end
      end
      LK_LOCKED: begin
        if (frame_fail) begin
          state_d = LK_HUNT;
          bal_d   = '0;
        end
      end
      default: state_d = LK_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= LK_HUNT;
      bal_q   <= '0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bal_q   <= bal_d;
      ferr_q  <= ferr_d;
    end
  end

  assign lock_o      = frame_en;
  assign frame_err_o = ferr_q;

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(lock_o) |-> $past(per_bal));

  // R8
  ferr_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    frame_err_o |-> !lock_o);

  // R7
  vld_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    word_vld_o |-> (lock_o && !frame_err_o));

  // R9
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    frame_err_o |=> !frame_err_o);

  // R11
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    lock_o |-> (bal_q == '0));

endmodule

// File: tb/frame_lock_rx_bench.sv
module frame_lock_rx_bench;

  localparam int DATA_W       = 8;
  localparam int SYNC_PERIODS = 4;
  localparam int RUN_MAX      = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ser_in;
  logic              lock_o;
  logic [DATA_W-1:0] word_o;
  logic              word_vld_o;
  logic              frame_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  frame_lock_rx #(.DATA_W(DATA_W), .SYNC_PERIODS(SYNC_PERIODS), .RUN_MAX(RUN_MAX))
  u_frame_lock_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .lock_o      (lock_o),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .frame_err_o (frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bit; return at the following falling edge, where the
  // registered outputs show the result of sampling it
  task automatic tick(input logic b);
    ser_in = b;
    @(negedge clk);
  endtask

  function automatic int rand_len();
    return 1 + int'($urandom_range(RUN_MAX - 2));
  endfunction

  function automatic logic [DATA_W-1:0] rand_word();
    return DATA_W'($urandom);
  endfunction

  function automatic bit good_frame(input logic start_b, input logic stop_b);
    return start_b && !stop_b;
  endfunction

  task automatic send_period(input int ones, input int zeros);
    for (int i = 0; i < ones; i++)  tick(1'b1);
    for (int i = 0; i < zeros; i++) tick(1'b0);
  endtask

  // Payload MSB first then stop bit; start bit sent by caller
  task automatic send_body(input logic [DATA_W-1:0] w, input logic stop_b, input string req);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      tick(w[i]);
      chk(word_vld_o == 1'b0, req, word_vld_o, 0);
    end
    tick(stop_b);
    if (good_frame(1'b1, stop_b)) begin
      chk(word_vld_o == 1'b1, req, word_vld_o, 1);
      chk(word_o == w, req, word_o, w);
      chk(lock_o == 1'b1, req, lock_o, 1);
    end
  endtask

  initial begin
    logic [DATA_W-1:0] w;
    int n;
    void'($urandom(32'd20241));
    rst_n  = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk({lock_o, word_vld_o, frame_err_o} == 3'b000, "R1 reset", {lock_o, word_vld_o, frame_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick(1'b0);
    chk({lock_o, word_vld_o, frame_err_o} == 3'b000, "R1 after release", {lock_o, word_vld_o, frame_err_o}, 0);

    // R2 R3: random-length balanced training; lock only on closing 1
    for (int p = 0; p < SYNC_PERIODS; p++) begin
      n = rand_len();
      send_period(n, n);
      chk(lock_o == 1'b0, "R3 early", lock_o, 0);
    end
    tick(1'b1);
    chk(lock_o == 1'b1, "R3 lock on closing 1", lock_o, 1);
    send_body(8'hA5, 1'b0, "R6 first word");

    // R10 back-to-back random frames
    for (int f = 0; f < 20; f++) begin
      tick(1'b1);
      chk(word_vld_o == 1'b0, "R7 strobe one cycle", word_vld_o, 0);
      w = rand_word();
      send_body(w, 1'b0, "R10 stream");
    end

    // R8 bad stop bit
    tick(1'b1);
    send_body(8'h3C, 1'b1, "R8");
    chk(frame_err_o == 1'b1, "R8 ferr", frame_err_o, 1);
    chk(lock_o == 1'b0, "R8 unlock", lock_o, 0);
    chk(word_vld_o == 1'b0, "R8 no strobe", word_vld_o, 0);
    tick(1'b0);
    chk(frame_err_o == 1'b0, "R8 pulse width", frame_err_o, 0);

    // R4 unbalanced period restarts the count
    for (int p = 0; p < SYNC_PERIODS - 1; p++) send_period(2, 2);
    send_period(2, 3);
    for (int p = 0; p < SYNC_PERIODS - 1; p++) send_period(2, 2);
    tick(1'b1);
    chk(lock_o == 1'b0, "R4 no lock after restart", lock_o, 0);
    tick(1'b0);
    tick(1'b1);
    chk(lock_o == 1'b1, "R4 lock after full count", lock_o, 1);
    w = rand_word();
    send_body(w, 1'b0, "R11 relock word");

    // R9 start bit of 0
    tick(1'b0);
    chk(frame_err_o == 1'b1, "R9 ferr", frame_err_o, 1);
    chk(lock_o == 1'b0, "R9 unlock", lock_o, 0);
    tick(1'b0);
    chk(frame_err_o == 1'b0, "R9 pulse width", frame_err_o, 0);

    // R5 runs at the limit never balance
    for (int p = 0; p < SYNC_PERIODS + 1; p++) send_period(RUN_MAX, RUN_MAX);
    tick(1'b1);
    chk(lock_o == 1'b0, "R5 saturated run", lock_o, 0);
    // R5 longest allowed run: complete a RUN_MAX-1 period from the 1 just sent
    send_period(RUN_MAX - 2, RUN_MAX - 1);
    for (int p = 0; p < SYNC_PERIODS - 1; p++) send_period(RUN_MAX - 1, RUN_MAX - 1);
    tick(1'b1);
    chk(lock_o == 1'b1, "R5 longest run locks", lock_o, 1);
    w = rand_word();
    send_body(w, 1'b0, "R11 after relock");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule